// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block works out the memory address for a single-word load or store, together with the new base-register value that the instruction may write back. Each request carries the base value, a 12-bit offset field, a 5-bit mode, an index-register value and the current carry flag. The offset is either the 12-bit field itself or the index register passed through an immediate shift. The amount and kind of that shift are encoded inside the same 12-bit field.

The mode chooses one of three addressing forms. In post-indexed form the access uses the unmodified base and the modified base is written back. In offset form the access uses the modified base and nothing is written back. In pre-indexed form the access uses the modified base and that same value is written back. Mode encodings that are not defined raise an undefined-instruction flag and suppress writeback. The result is registered and appears one clock after the request.

Top module: `ldst_agen`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, every output is 0.
- R2: A request on `req_valid` produces `out_valid`=1 exactly one clock later. A cycle with no request produces `out_valid`=0, `out_wb_en`=0 and `out_undef`=0 one clock later.
- R3: Post-indexed form (mode bit 3 = 0): `out_addr` equals the base, `out_wb_en`=1 and `out_wb_data` is the base adjusted by the offset. This holds whatever the value of mode bit 0.
- R4: Offset form (mode bit 3 = 1, bit 0 = 0): `out_addr` is the base adjusted by the offset and `out_wb_en`=0.
- R5: Pre-indexed form (mode bit 3 = 1, bit 0 = 1): `out_addr` is the base adjusted by the offset, `out_wb_en`=1 and `out_wb_data` equals `out_addr`.
- R6: Mode bit 2 = 1 adds the offset and bit 2 = 0 subtracts it, modulo 2^32. This applies in every form, including post-indexed with a register index.
- R7: Mode bit 4 = 0 selects the immediate offset, which is `req_ofs[11:0]` zero-extended.
- R8: Mode bit 4 = 1 with shift kind `req_ofs[6:4]`=000 uses the index shifted left by `req_ofs[11:7]`. An amount of 0 leaves the index unchanged.
- R9: Mode bit 4 = 1 with shift kind 110 and a nonzero amount `req_ofs[11:7]` uses the index rotated right by that amount.
- R10: Mode bit 4 = 1 with shift kind 110 and amount 0 uses the index shifted right by one, with `req_carry` placed in bit 31.
- R11: Mode bit 1 = 1 sets `out_undef`=1 and `out_wb_en`=0.
- R12: Mode bit 4 = 1 with any shift kind other than 000 or 110 sets `out_undef`=1 and `out_wb_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 5 | Bit4 register index, bit3 pre, bit2 up, bit1 must be 0, bit0 writeback |
| req_ofs | input | 12 | Immediate offset, or {amount[11:7], kind[6:4], unused[3:0]} |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_carry | input | 1 | Carry flag for rotate-through-carry |
| out_valid | output | 1 | Result present |
| out_addr | output | 32 | Effective access address |
| out_wb_data | output | 32 | New base value |
| out_wb_en | output | 1 | Write the new base value back |
| out_undef | output | 1 | Undefined mode or shift kind |

## Verification
The checker assumes that the request inputs hold known values across each rising edge and are only meaningful when `req_valid` is high. Its properties compare outputs against `$past` of the inputs one edge earlier, so they also assume a request is never held across reset release. The bench changes inputs only on falling edges. It releases reset with `req_valid` low. It covers every mode value and every shift kind, together with random bases and indices, so that both legal and illegal encodings reach the checker.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;

    localparam int unsigned AMT_W   = 5;
    localparam int unsigned AMT_LSB = 7;
    localparam int unsigned KIND_W  = 3;
    localparam int unsigned KIND_LSB = 4;

    localparam logic [KIND_W-1:0] KIND_LSL = 3'b000;
    localparam logic [KIND_W-1:0] KIND_ROR = 3'b110;

    typedef struct packed {
        logic use_index;
        logic pre;
        logic up;
        logic wb;
        logic use_ror;
        logic legal;
    } agen_dec_t;

endpackage

// File: rtl/agen_mode_dec.sv
module agen_mode_dec
    import ldst_agen_pkg::*;
(
    input  logic [4:0]        mode,
    input  logic [KIND_W-1:0] kind,
    output agen_dec_t         dec
);
    logic kind_ok;

    always_comb begin
        kind_ok        = (kind == KIND_LSL) || (kind == KIND_ROR);
        dec.use_index  = mode[4];
        dec.pre        = mode[3];
        dec.up         = mode[2];
        dec.wb         = !mode[3] || mode[0];
        dec.use_ror    = (kind == KIND_ROR);
        dec.legal      = !mode[1] && (!mode[4] || kind_ok);
    end
endmodule

// File: rtl/agen_index_shift.sv
module agen_index_shift #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 5
) (
    input  logic [DATA_W-1:0] idx,
    input  logic [AMT_W-1:0]  amt,
    input  logic              use_ror,
    input  logic              carry,
    output logic [DATA_W-1:0] shifted
);
    localparam int unsigned DBL_W = 2 * DATA_W;

    logic [DBL_W-1:0] dbl;
    logic [DBL_W-1:0] dbl_sh;

    always_comb begin
        dbl    = {idx, idx};
        dbl_sh = dbl >> amt;
        if (!use_ror) begin
            shifted = idx << amt;
        end else if (amt == '0) begin
            shifted = {carry, idx[DATA_W-1:1]};
        end else begin
            shifted = dbl_sh[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
    import ldst_agen_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_mode,
    input  logic [IMM_W-1:0]  req_ofs,
    input  logic [DATA_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_index,
    input  logic              req_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wb_data,
    output logic              out_wb_en,
    output logic              out_undef
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic              wb_en;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wb_data;
    } res_t;

    res_t      res_d, res_q;
    agen_dec_t dec;
    logic [DATA_W-1:0] idx_sh;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] moved;

    agen_mode_dec u_dec (
        .mode (req_mode),
        .kind (req_ofs[KIND_LSB +: KIND_W]),
        .dec  (dec)
    );

    agen_index_shift #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_shift (
        .idx     (req_index),
        .amt     (req_ofs[AMT_LSB +: AMT_W]),
        .use_ror (dec.use_ror),
        .carry   (req_carry),
        .shifted (idx_sh)
    );

    always_comb begin
        res_d  = res_q;
        offset = dec.use_index ? idx_sh : {{PAD_W{1'b0}}, req_ofs};
        moved  = dec.up ? (req_base + offset) : (req_base - offset);
        res_d.valid = req_valid;
        res_d.undef = req_valid && !dec.legal;
        res_d.wb_en = req_valid && dec.legal && dec.wb;
        if (req_valid) begin
            res_d.addr    = dec.pre ? moved : req_base;
            res_d.wb_data = moved;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_addr    = res_q.addr;
    assign out_wb_data = res_q.wb_data;
    assign out_wb_en   = res_q.wb_en;
    assign out_undef   = res_q.undef;
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [4:0]        req_mode,
    input logic [IMM_W-1:0]  req_ofs,
    input logic [DATA_W-1:0] req_base,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_wb_data,
    input logic              out_wb_en,
    input logic              out_undef
);
    logic imm_ok;
    assign imm_ok = req_valid && !req_mode[4] && !req_mode[1];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);                                        // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wb_en && !out_undef));                      // R2
    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_ok && !req_mode[3]) |=> (out_wb_en && out_addr == $past(req_base))); // R3
    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[3] && !req_mode[0]) |=> !out_wb_en);      // R4
    AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_ok && req_mode[3] && req_mode[0]) |=> (out_wb_en && out_wb_data == out_addr)); // R5
    AST_IMM_UP_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_ok && req_mode[2]) |=> (out_wb_data == $past(req_base) + DATA_W'($past(req_ofs)))); // R7
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[1]) |=> (out_undef && !out_wb_en));       // R11
    AST_UNDEF_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> !out_wb_en);                                       // R12
endmodule

bind ldst_agen ldst_agen_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_ofs     (req_ofs),
    .req_base    (req_base),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_wb_data (out_wb_data),
    .out_wb_en   (out_wb_en),
    .out_undef   (out_undef)
);

// File: tb/tb_ldst_agen.sv
module tb_ldst_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_mode = '0;
    logic [11:0] req_ofs = '0;
    logic [31:0] req_base = '0;
    logic [31:0] req_index = '0;
    logic        req_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_wb_data;
    logic        out_wb_en;
    logic        out_undef;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ldst_agen dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_mode (req_mode),
        .req_ofs (req_ofs), .req_base (req_base), .req_index (req_index),
        .req_carry (req_carry), .out_valid (out_valid), .out_addr (out_addr),
        .out_wb_data (out_wb_data), .out_wb_en (out_wb_en), .out_undef (out_undef)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: returns the offset and the requirement it exercises.
    function automatic logic [31:0] ref_offset(input logic [4:0] m, input logic [11:0] f,
                                               input logic [31:0] x, input logic c,
                                               output string tag);
        int amt = int'(f[11:7]);
        int kind = int'(f[6:4]);
        logic [31:0] r;
        if (!m[4]) begin
            tag = "R7"; r = {20'd0, f};
        end else if (kind == 0) begin
            tag = "R8"; r = x << amt;
        end else if (amt == 0) begin
            tag = "R10"; r = {c, x[31:1]};
        end else begin
            tag = "R9"; r = (x >> amt) | (x << (32 - amt));
        end
        return r;
    endfunction

    task automatic step(input logic v, input logic [4:0] m, input logic [11:0] f,
                        input logic [31:0] b, input logic [31:0] x, input logic c);
        string otag, ftag;
        logic [31:0] off, sum, e_addr;
        logic e_undef, e_wb;
        int kind;
        @(negedge clk);
        req_valid = v; req_mode = m; req_ofs = f;
        req_base = b; req_index = x; req_carry = c;
        kind = int'(f[6:4]);
        off = ref_offset(m, f, x, c, otag);
        sum = m[2] ? b + off : b - off;                       // R6
        e_undef = m[1] || (m[4] && kind != 0 && kind != 6);
        e_wb = !e_undef && (!m[3] || m[0]);
        e_addr = m[3] ? sum : b;
        if (m[1]) ftag = "R11";
        else if (e_undef) ftag = "R12";
        else if (!m[3]) ftag = "R3";
        else if (m[0]) ftag = "R5";
        else ftag = "R4";
        @(posedge clk);
        #1;
        check("R2", "out_valid", 32'(out_valid), 32'(v));
        if (!v) begin
            check("R2", "idle wb_en", 32'(out_wb_en), 32'd0);
            check("R2", "idle undef", 32'(out_undef), 32'd0);
        end else begin
            check(ftag, "undef", 32'(out_undef), 32'(e_undef));
            check(ftag, "wb_en", 32'(out_wb_en), 32'(e_wb));
            if (!e_undef) begin
                check({ftag, "/", otag, "/R6"}, "addr", out_addr, e_addr);
                check({ftag, "/", otag, "/R6"}, "wb_data", out_wb_data, sum);
            end
        end
    endtask

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "valid", 32'(out_valid), 32'd0);
        check("R1", "addr", out_addr, 32'd0);
        check("R1", "wb_data", out_wb_data, 32'd0);
        check("R1", "wb_en", 32'(out_wb_en), 32'd0);
        check("R1", "undef", 32'(out_undef), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 post subtract and add with immediate (R7)
        step(1, 5'd0,  12'h010, 32'h0000_1000, 32'h0, 0);
        step(1, 5'd1,  12'hFFF, 32'h0000_0100, 32'h0, 0);
        step(1, 5'd5,  12'h004, 32'hFFFF_FFFE, 32'h0, 0);   // R6 wrap
        // R4 offset forms
        step(1, 5'd8,  12'h020, 32'h0000_0010, 32'h0, 0);   // R6 wrap below zero
        step(1, 5'd12, 12'h123, 32'h4000_0000, 32'h0, 0);
        // R5 pre-indexed writeback
        step(1, 5'd9,  12'h00C, 32'h0000_2000, 32'h0, 0);
        step(1, 5'd13, 12'h800, 32'h0000_2000, 32'h0, 0);
        step(0, 5'd13, 12'h800, 32'h0000_2000, 32'h0, 0);   // R2 idle
        // R8 LSL amount 3 and amount 0; R6 post add with register index
        step(1, 5'd20, {5'd3, 3'b000, 4'h0}, 32'h0000_1000, 32'h0000_0011, 0);
        step(1, 5'd21, {5'd0, 3'b000, 4'hF}, 32'h0000_1000, 32'h0000_0011, 0);
        step(1, 5'd16, {5'd31, 3'b000, 4'h0}, 32'h0000_1000, 32'h0000_0003, 0);
        // R9 ROR by 4
        step(1, 5'd28, {5'd4, 3'b110, 4'h0}, 32'h0000_0000, 32'h1234_5678, 0);
        step(1, 5'd25, {5'd1, 3'b110, 4'h0}, 32'h8000_0000, 32'h0000_0001, 0);
        // R10 RRX with carry set and clear
        step(1, 5'd29, {5'd0, 3'b110, 4'h0}, 32'h0000_0000, 32'h0000_0003, 1);
        step(1, 5'd24, {5'd0, 3'b110, 4'h0}, 32'h0000_0100, 32'h0000_0003, 0);
        // R11 mode bit 1 set
        step(1, 5'd2,  12'h004, 32'h0000_1000, 32'h0, 0);
        step(1, 5'd31, 12'h000, 32'h0000_1000, 32'h0, 0);
        // R12 unsupported shift kinds
        step(1, 5'd29, {5'd2, 3'b010, 4'h0}, 32'h0000_1000, 32'h5, 0);
        step(1, 5'd17, {5'd2, 3'b100, 4'h0}, 32'h0000_1000, 32'h5, 0);

        for (int i = 0; i < 600; i++) begin
            logic [11:0] f;
            f = 12'($urandom);
            if (i % 3 == 0) f[6:4] = 3'b000;
            else if (i % 3 == 1) f[6:4] = 3'b110;
            if (i % 7 == 0) f[11:7] = 5'd0;
            step(($urandom % 5) != 0, 5'(i % 32), f, $urandom, $urandom, 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule